// File: doc/BRIEF.md
# Wake-up Input Event Detector

This block watches eight external input lines and turns selected activity on them into a single interrupt request. For each line, software picks whether the line reacts to a level (high or low) or to a transition (rising, falling, or both). A detected event sets a sticky pending flag for that line. The pending flags are combined with per-line interrupt enables to form one request output.

Each line also has an input-enable that gates the line before detection. A gated-off line reads as 0. Turning the gate on or off while the line is high therefore looks like a transition, and can set a pending flag on its own. Software is expected to clear the pending flags after changing a gate. Pending flags are cleared by writing ones to a dedicated clear location on a small synchronous byte-wide register bus. Reads on that bus are combinational from the address.

Top module: `wkup_unit`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `irq_out` is 0.
- R2: A mode bit of 1 selects level detection for its line. In level mode, a polarity bit of 0 fires while the gated line is high, and a polarity bit of 1 fires while it is low.
- R3: A mode bit of 0 selects edge detection. With the both-edges bit clear, a polarity bit of 0 fires on a rising transition and a polarity bit of 1 fires on a falling transition.
- R4: In edge mode, a both-edges bit of 1 makes a transition in either direction fire, whatever the polarity bit says. In level mode, the both-edges bit has no effect.
- R5: Pending bits are sticky. Writing 1 to a bit of the clear location clears that pending bit, and writing 0 leaves it unchanged. An event in the same cycle as a clear wins, so an active level re-sets its bit at once.
- R6: `irq_out` is 1 exactly when some bit is set in both the pending and the interrupt-enable registers. Pending bits latch events even while their interrupt enable is 0.
- R7: An input-enable bit of 0 forces its line to 0 before detection. Setting that bit while the line is high produces a rising transition that can set the pending bit.
- R8: A change on `pins_in` first shows in the pending register after the third rising clock edge, counted from the change. This delay comes from two synchronizer stages and one pending register.
- R9: The register map uses these addresses:
  - 0: mode
  - 1: polarity
  - 2: both-edges
  - 3: input-enable
  - 4: interrupt-enable
  - 5: pending (read-only; writes are ignored)
  - 6: clear (write-only; reads as 0)
  - 7: reads as 0.

  Addresses 0 to 4 are read/write and read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 3 | Register address, used for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pins_in | input | 8 | Asynchronous wake-up input lines |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The embedded properties check three things on every cycle:
- A pending bit never drops unless its clear bit was written.
- A pending bit never rises without a detected event.
- Any line that reports an event holds that bit in the following cycle.

They also check two conditions on every cycle:
- An edge-mode event always coincides with a real change of the gated line.
- A gated-off line never reports a rising edge.

Only the bench scenarios can show several things the properties do not:
- The actual trigger selection for each mode and polarity combination.
- The three-edge latency from pin to pending.
- The spurious event when an input gate is opened.
- The register map decoding.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

    localparam int NUM_IN  = 8;
    localparam int ADDR_W  = 3;
    localparam int SYNC_ST = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE  = 3'd0,
        A_POL   = 3'd1,
        A_BOTH  = 3'd2,
        A_INEN  = 3'd3,
        A_IRQEN = 3'd4,
        A_PEND  = 3'd5,
        A_CLR   = 3'd6,
        A_RSVD  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [NUM_IN-1:0] mode;   // 1 = level, 0 = edge
        logic [NUM_IN-1:0] pol;    // level: 0 high / 1 low; edge: 0 rise / 1 fall
        logic [NUM_IN-1:0] both;   // edge mode: fire on either transition
        logic [NUM_IN-1:0] inen;   // input gate
        logic [NUM_IN-1:0] irqen;  // interrupt mask
    } wk_cfg_t;

    function automatic logic bit_event(input logic lvl_mode, input logic pol_b,
                                       input logic both_b, input logic cur,
                                       input logic prv);
        logic ev;
        if (lvl_mode)
            ev = pol_b ? ~cur : cur;
        else if (both_b)
            ev = cur ^ prv;
        else
            ev = pol_b ? (~cur & prv) : (cur & ~prv);
        return ev;
    endfunction

endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wkup_detect.sv
module wkup_detect
    import wkup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] line,
    input  wk_cfg_t           cfg,
    output logic [NUM_IN-1:0] evt
);
    logic [NUM_IN-1:0] gated;
    logic [NUM_IN-1:0] prev_q;

    assign gated = line & cfg.inen;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= gated;
    end

    generate
        for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
            assign evt[i] = bit_event(cfg.mode[i], cfg.pol[i], cfg.both[i],
                                      gated[i], prev_q[i]);
        end
    endgenerate

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        ((evt & ~cfg.mode & ~(gated ^ prev_q)) == '0)); // R3

    AST_GATED_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        ((evt & ~cfg.mode & ~cfg.pol & ~cfg.both & ~cfg.inen) == '0)); // R7
endmodule

// File: rtl/wkup_pending.sv
module wkup_pending
    import wkup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] evt,
    input  logic [NUM_IN-1:0] clr_mask,
    output logic [NUM_IN-1:0] pend
);
    logic [NUM_IN-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_mask) | evt;
    end

    assign pend = pend_q;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend_q) & ~$past(clr_mask) & ~pend_q) == '0)); // R5

    AST_PEND_CAUSED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt)) == '0)); // R5

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(evt)) == $past(evt))); // R5
endmodule

// File: rtl/wkup_regs.sv
module wkup_regs
    import wkup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_IN-1:0] wdata,
    input  logic [NUM_IN-1:0] pend,
    output logic [NUM_IN-1:0] rdata,
    output logic [NUM_IN-1:0] clr_mask,
    output wk_cfg_t           cfg
);
    wk_cfg_t   cfg_q;
    reg_addr_e sel;

    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (sel)
                A_MODE:  cfg_q.mode  <= wdata;
                A_POL:   cfg_q.pol   <= wdata;
                A_BOTH:  cfg_q.both  <= wdata;
                A_INEN:  cfg_q.inen  <= wdata;
                A_IRQEN: cfg_q.irqen <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            A_MODE:  rdata = cfg_q.mode;
            A_POL:   rdata = cfg_q.pol;
            A_BOTH:  rdata = cfg_q.both;
            A_INEN:  rdata = cfg_q.inen;
            A_IRQEN: rdata = cfg_q.irqen;
            A_PEND:  rdata = pend;
            default: rdata = '0;
        endcase
    end

    assign clr_mask = (wr_en && sel == A_CLR) ? wdata : '0;
    assign cfg      = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_q)); // R9
endmodule

// File: rtl/wkup_unit.sv
module wkup_unit
    import wkup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_IN-1:0] wdata,
    output logic [NUM_IN-1:0] rdata,
    input  logic [NUM_IN-1:0] pins_in,
    output logic              irq_out
);
    wk_cfg_t           cfg;
    logic [NUM_IN-1:0] line_s;
    logic [NUM_IN-1:0] evt;
    logic [NUM_IN-1:0] pend;
    logic [NUM_IN-1:0] clr_mask;

    wkup_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pend(pend), .rdata(rdata), .clr_mask(clr_mask), .cfg(cfg)
    );

    wkup_sync #(.W(NUM_IN), .STAGES(SYNC_ST)) u_sync (
        .clk(clk), .rst(rst), .d(pins_in), .q(line_s)
    );

    wkup_detect u_detect (
        .clk(clk), .rst(rst), .line(line_s), .cfg(cfg), .evt(evt)
    );

    wkup_pending u_pend (
        .clk(clk), .rst(rst), .evt(evt), .clr_mask(clr_mask), .pend(pend)
    );

    assign irq_out = |(pend & cfg.irqen);

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (cfg.irqen != '0)); // R6

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (pend != '0)); // R6
endmodule

// File: tb/wkup_unit_bench.sv
`timescale 1ns/1ps
module wkup_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pins_in = 8'h00;
    logic       irq_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    wkup_unit u_wkup_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pins_in(pins_in), .irq_out(irq_out)
    );

    // {mode, pol, both, pins_before, pins_after, expected_pending}
    localparam logic [47:0] VEC [8] = '{
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h0F},  // R3 rising
        {8'h00, 8'hFF, 8'h00, 8'hFF, 8'hF0, 8'h0F},  // R3 falling
        {8'h00, 8'hAA, 8'hFF, 8'h33, 8'h55, 8'h66},  // R4 both edges
        {8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00},  // R3 fall ignored
        {8'hFF, 8'h00, 8'h00, 8'h01, 8'h80, 8'h81},  // R2 level high
        {8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hF0, 8'h0F},  // R2 level low
        {8'hF0, 8'hCC, 8'h00, 8'h00, 8'hFF, 8'hF3},  // R2 R3 mixed
        {8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00}   // R4 ignored in level
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [7:0] r;

        // R1: reset state
        wait_cyc(3);
        @(negedge clk); rst = 1'b0;
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], r);
            check(r, 8'h00, "R1 reg after reset");
        end
        check({7'd0, irq_out}, 8'h00, "R1 irq after reset");

        // R9: register map readback
        wr(3'd0, 8'hA5); rd(3'd0, r); check(r, 8'hA5, "R9 mode readback");
        wr(3'd1, 8'h5A); rd(3'd1, r); check(r, 8'h5A, "R9 pol readback");
        wr(3'd2, 8'h3C); rd(3'd2, r); check(r, 8'h3C, "R9 both readback");
        wr(3'd4, 8'hC3); rd(3'd4, r); check(r, 8'hC3, "R9 irqen readback");
        wr(3'd6, 8'hFF); rd(3'd6, r); check(r, 8'h00, "R9 clear reads 0");
        rd(3'd7, r); check(r, 8'h00, "R9 addr7 reads 0");
        wr(3'd4, 8'h00);
        wr(3'd3, 8'hFF);

        // Table walk
        for (int v = 0; v < 8; v++) begin
            logic [47:0] e;
            e = VEC[v];
            wr(3'd0, e[47:40]);
            wr(3'd1, e[39:32]);
            wr(3'd2, e[31:24]);
            pins_in = e[23:16];
            wait_cyc(4);
            wr(3'd6, 8'hFF);
            pins_in = e[15:8];
            wait_cyc(4);
            rd(3'd5, r);
            check(r, e[7:0], $sformatf("R2/R3/R4 vector %0d", v));
        end

        // R9: pending is read-only
        wr(3'd5, 8'h00); rd(3'd5, r); check(r, 8'h00 | VEC[7][7:0], "R9 pend write ignored");

        // R8: latency from pin to pending, rising edge mode
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        pins_in = 8'h00; wait_cyc(4); wr(3'd6, 8'hFF);
        pins_in = 8'h01;
        @(negedge clk); rd(3'd5, r); check(r, 8'h00, "R8 after edge 1");
        @(negedge clk); rd(3'd5, r); check(r, 8'h00, "R8 after edge 2");
        @(negedge clk); rd(3'd5, r); check(r, 8'h01, "R8 after edge 3");

        // R6: pending latched with interrupt disabled, then masking
        check({7'd0, irq_out}, 8'h00, "R6 irq masked");
        wr(3'd4, 8'h02); check({7'd0, irq_out}, 8'h00, "R6 other bit enabled");
        wr(3'd4, 8'h01); check({7'd0, irq_out}, 8'h01, "R6 irq asserted");

        // R5: partial write-one-to-clear
        pins_in = 8'h00; wait_cyc(4); wr(3'd6, 8'hFF);
        pins_in = 8'h0F; wait_cyc(4);
        wr(3'd6, 8'h05); rd(3'd5, r); check(r, 8'h0A, "R5 partial clear");
        wr(3'd6, 8'h00); rd(3'd5, r); check(r, 8'h0A, "R5 zero write no effect");
        check({7'd0, irq_out}, 8'h00, "R6 irq drops after clear");

        // R5: level re-sets immediately after clear
        wr(3'd0, 8'hFF); wr(3'd1, 8'h00);
        pins_in = 8'h80; wait_cyc(4);
        wr(3'd6, 8'hFF); rd(3'd5, r); check(r, 8'h80, "R5 level re-set after clear");

        // R7: gated-off inputs ignored, then spurious event on enable
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h00);
        pins_in = 8'h00; wait_cyc(4);
        wr(3'd6, 8'hFF);
        pins_in = 8'hFF; wait_cyc(4);
        rd(3'd5, r); check(r, 8'h00, "R7 gated input ignored");
        wr(3'd3, 8'h01); wait_cyc(3);
        rd(3'd5, r); check(r, 8'h01, "R7 spurious event on enable");

        // R1: reset clears state again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(3'd5, r); check(r, 8'h00, "R1 pend after second reset");
        rd(3'd3, r); check(r, 8'h00, "R1 inen after second reset");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule